// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Routing

This block gathers 32 level-sensitive interrupt inputs and gives a primary interrupt controller a single combined request. Each input is registered into a raw level register. A software-controlled enable mask selects which of those levels may raise the combined request line. Software can also raise a request on line 0 through a pair of set/clear words that act on mask bit 0.

A subset of the inputs, lines 21 to 30, can also bypass the combined request. Each of these lines has its own bit in a separate direct-routing enable register. When that bit is set, the line's registered level is driven onto its own output, which connects to the matching primary-controller input. Software reaches all state through a word-indexed register window of 4 KB on a simple single-cycle request bus. Read data appears one clock after the read request.

Top module: `irq_fanin_ctrl`

## Requirements
- R1: After reset the level, mask and direct-enable registers are zero. `irq_combined`, every `irq_direct` bit and `bus_rdata` are low.
- R2: `irq_combined` is high exactly when the registered level AND the enable mask is non-zero. The level register samples `irq_in` on every clock, so a change at the input reaches the output one clock later.
- R3: A read request (`bus_req`=1, `bus_wr`=0) returns its data on `bus_rdata` after the next clock edge. Word 0 (byte address 0x000) returns level AND mask, word 1 (0x004) returns the raw level and word 2 (0x008) returns the mask.
- R4: A write to word 2 ORs `bus_wdata` into the mask. A write to word 3 (0x00C) clears each mask bit that is set in `bus_wdata`. The new mask takes effect at the edge of the write.
- R5: A non-zero write to word 4 (0x010) sets mask bit 0, and a non-zero write to word 5 (0x014) clears it. A zero write to either word has no effect. A read of word 4 returns raw level bit 0 in bit 0 and zeros elsewhere.
- R6: `irq_direct[k]` equals level bit 21+k AND direct-enable bit k, for k = 0..9. It changes one clock after the input or the enable, and it does not depend on the enable mask.
- R7: A write to word 8 (0x020) ORs `bus_wdata` bits 30:21 into the direct-enable register, and all other data bits are ignored. A write to word 9 (0x024) clears each direct-enable bit whose data bit 21+k is set. A read of word 8 returns the direct-enable register in bits 30:21 and zeros elsewhere.
- R8: A read of any word other than 0, 1, 2, 4 and 8 returns zero. A write to any word other than 2, 3, 4, 5, 8 and 9 changes no state.
- R9: The word index is taken from `bus_addr[11:2]`, so bits 1:0 are ignored. `bus_rdata` holds its last read value through idle cycles and write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| bus_req | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read request |
| irq_combined | output | 1 | Combined request to the primary controller |
| irq_direct | output | 10 | Direct-routed lines 21..30 |

## Verification
A corrupted mask or level register shows up at `irq_combined` in the cycle after its cause, and at the status and mask reads one clock after the next read request. A wrong direct-enable bit is seen on its `irq_direct` line one clock after the input level changes, independent of the mask, and in the read of word 8. Decode errors show up as non-zero reads of unused words, or as mask and enable changes after writes to unused words. The next read of word 2 or word 8 exposes these.

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl #(
  parameter int N_IN   = 32,
  parameter int ADDR_W = 12,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   irq_in,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_IN-1:0]   bus_wdata,
  output logic [N_IN-1:0]   bus_rdata,
  output logic              irq_combined,
  output logic [PT_HI-PT_LO:0] irq_direct
);
  localparam int PT_N   = PT_HI - PT_LO + 1;
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_STAT  = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_RAW   = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_MSET  = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_MCLR  = WORD_W'(3);
  localparam logic [WORD_W-1:0] W_SWSET = WORD_W'(4);
  localparam logic [WORD_W-1:0] W_SWCLR = WORD_W'(5);
  localparam logic [WORD_W-1:0] W_DSET  = WORD_W'(8);
  localparam logic [WORD_W-1:0] W_DCLR  = WORD_W'(9);

  logic [N_IN-1:0]   level_q, mask_q, rd_mux;
  logic [PT_N-1:0]   den_q;
  logic [WORD_W-1:0] word;
  logic              wr_en, rd_en, unused_addr_lsb;

  assign word            = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign wr_en           = bus_req & bus_wr;
  assign rd_en           = bus_req & ~bus_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) level_q <= '0;
    else        level_q <= irq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_en) begin
      case (word)
        W_MSET:  mask_q    <= mask_q | bus_wdata;
        W_MCLR:  mask_q    <= mask_q & ~bus_wdata;
        W_SWSET: if (|bus_wdata) mask_q[0] <= 1'b1;
        W_SWCLR: if (|bus_wdata) mask_q[0] <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q <= '0;
    end else if (wr_en) begin
      if (word == W_DSET) den_q <= den_q | bus_wdata[PT_HI:PT_LO];
      if (word == W_DCLR) den_q <= den_q & ~bus_wdata[PT_HI:PT_LO];
    end
  end

  always_comb begin
    case (word)
      W_STAT:  rd_mux = level_q & mask_q;
      W_RAW:   rd_mux = level_q;
      W_MSET:  rd_mux = mask_q;
      W_SWSET: rd_mux = {{(N_IN-1){1'b0}}, level_q[0]};
      W_DSET:  rd_mux = N_IN'(den_q) << PT_LO;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;

  assign irq_combined = |(level_q & mask_q);

  for (genvar k = 0; k < PT_N; k++) begin : g_direct
    assign irq_direct[k] = level_q[PT_LO+k] & den_q[k];
  end
endmodule

// File: rtl/irq_fanin_chk.sv
module irq_fanin_chk #(
  parameter int N_IN   = 32,
  parameter int ADDR_W = 12,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_IN-1:0]   irq_in,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N_IN-1:0]   bus_wdata,
  input logic [N_IN-1:0]   bus_rdata,
  input logic              irq_combined,
  input logic [PT_HI-PT_LO:0] irq_direct
);
  logic [ADDR_W-3:0] w;
  logic rd_undef;
  assign w = bus_addr[ADDR_W-1:2];
  assign rd_undef = !(w == 0 || w == 1 || w == 2 || w == 4 || w == 8);

  assert_combined_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_combined |-> ($past(irq_in) != '0));

  assert_mask_clear_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && w == 3 && bus_wdata == '1) |=> !irq_combined);

  assert_direct_follows_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_direct & ~$past(irq_in[PT_HI:PT_LO])) == '0);

  assert_direct_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && w == 9 && bus_wdata == '1) |=> (irq_direct == '0));

  assert_undef_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && rd_undef) |=> (bus_rdata == '0));

  assert_rdata_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind irq_fanin_ctrl irq_fanin_chk #(
  .N_IN(N_IN), .ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_req(bus_req),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_combined(irq_combined), .irq_direct(irq_direct)
);

// File: tb/tb_irq_fanin_ctrl.sv
`timescale 1ns/1ps
module tb_irq_fanin_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [31:0] irq_in = '0, bus_wdata = '0;
  logic        bus_req = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_rdata;
  logic        irq_combined;
  logic [9:0]  irq_direct;

  int checks = 0, errors = 0;
  bit done = 0, rd_pending = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_fanin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_combined(irq_combined), .irq_direct(irq_direct)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_pending <= bus_req && !bus_wr;

  always @(negedge clk)
    if (rd_pending && exp_q.size() > 0)
      check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());

  task automatic bus_write(input int word, input logic [31:0] data);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = 12'(word << 2); bus_wdata = data;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [11:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = addr;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic set_in(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(32'(irq_combined), 0, "R1 combined after reset");
    check(32'(irq_direct), 0, "R1 direct after reset");
    check(bus_rdata, 0, "R1 rdata after reset");
    bus_read(12'h004, 0, "R1 level reset");
    bus_read(12'h008, 0, "R1 mask reset");
    bus_read(12'h020, 0, "R1 direct enable reset");

    set_in(32'h0000_0F00);
    check(32'(irq_combined), 0, "R2 masked input");
    bus_write(2, 32'h0000_0100);
    check(32'(irq_combined), 1, "R4 mask set raises R2 combined");
    bus_read(12'h000, 32'h0000_0100, "R3 status");
    bus_read(12'h004, 32'h0000_0F00, "R3 raw level");
    bus_read(12'h008, 32'h0000_0100, "R3 mask");
    bus_write(2, 32'h0002_0000);
    bus_read(12'h008, 32'h0002_0100, "R4 mask OR");
    bus_write(3, 32'h0000_0100);
    check(32'(irq_combined), 0, "R4 mask clear");
    bus_read(12'h008, 32'h0002_0000, "R4 mask after clear");
    set_in(32'h0002_0000);
    check(32'(irq_combined), 1, "R2 input rise one cycle");
    set_in(32'h0);
    check(32'(irq_combined), 0, "R2 input fall one cycle");

    bus_write(3, 32'hFFFF_FFFF);
    set_in(32'h0000_0001);
    bus_write(4, 32'h0);
    check(32'(irq_combined), 0, "R5 zero write ignored");
    bus_read(12'h008, 0, "R5 zero write mask");
    bus_write(4, 32'h5);
    check(32'(irq_combined), 1, "R5 software set");
    bus_read(12'h008, 32'h1, "R5 mask bit0");
    set_in(32'hFFFF_FFFE);
    bus_read(12'h010, 0, "R5 read word4 low");
    set_in(32'hFFFF_FFFF);
    bus_read(12'h010, 32'h1, "R5 read word4 bit0 only");
    bus_write(5, 32'h0);
    check(32'(irq_combined), 1, "R5 zero clear ignored");
    bus_write(5, 32'h2);
    check(32'(irq_combined), 0, "R5 software clear");
    bus_read(12'h008, 0, "R5 mask after clear");

    set_in(32'h4020_0000);
    bus_write(8, 32'hFFFF_FFFF);
    bus_read(12'h020, 32'h7FE0_0000, "R7 set masked to 30:21");
    check(32'(irq_direct), 32'h201, "R6 direct lines");
    check(32'(irq_combined), 0, "R6 bypasses mask");
    bus_write(9, 32'h4000_0000);
    check(32'(irq_direct), 32'h001, "R7 clear one line");
    bus_read(12'h020, 32'h3FE0_0000, "R7 read after clear");
    set_in(32'h2000_0000);
    check(32'(irq_direct), 32'h100, "R6 follows input");
    bus_write(9, 32'hFFFF_FFFF);
    check(32'(irq_direct), 0, "R7 clear all");

    bus_write(6, 32'hFFFF_FFFF);
    bus_write(7, 32'hFFFF_FFFF);
    bus_write(10, 32'hFFFF_FFFF);
    bus_read(12'h008, 0, "R8 undefined write mask");
    bus_read(12'h020, 0, "R8 undefined write direct");
    check(32'(irq_combined), 0, "R8 undefined write output");
    bus_read(12'h00C, 0, "R8 read word3");
    bus_read(12'h014, 0, "R8 read word5");
    bus_read(12'h024, 0, "R8 read word9");
    bus_read(12'hFFC, 0, "R8 read last word");

    set_in(32'h0000_0055);
    bus_read(12'h007, 32'h0000_0055, "R9 low address bits ignored");
    repeat (3) @(negedge clk);
    check(bus_rdata, 32'h0000_0055, "R9 holds when idle");
    bus_write(2, 32'h4);
    check(bus_rdata, 32'h0000_0055, "R9 holds on write");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule